// File: doc/BRIEF.md
# Concurrent On-Line Test Manager

This controller runs in-field tests of IP cores while applications keep running on an on-chip network. Network interfaces send it test requests. The manager holds a configuration: the number of test vectors, the target core address, a power budget, the power cost of a test, and a snapshot timeout. For each request it polls every managed interface for a power snapshot and waits for the replies. It then accepts the test only if the reported load plus the test cost fits the budget. An accepted test streams numbered vectors to the target. In every case the manager ends by answering the requester with an accept or reject response.

Several managers share the network and pass a single management token around a ring. A manager starts a test only while it owns the token. It gives the token back when a test finishes or when a hold limit runs out. Requests that arrive without the token wait in a small queue and are served in arrival order once the token comes back. Separately, any alarm raised by an interface makes the manager throttle all the interfaces it manages on the next cycle.

Top module: `olt_manager`

## Requirements
- R1: After synchronous reset, every message output (snapshot request, vector, delivery-done, response, throttle, token-out) is low and `tok_held` equals the START_TOKEN parameter (1 by default).
- R2: A configuration command is taken only while idle. It latches the vector count, target, budget, test cost and timeout, and it wins over a queued test request in the same cycle.
- R3: A test begins with a one-cycle snapshot request to all N_NI interfaces (`ss_req` all ones). The manager keeps collecting until every interface has answered once. A repeated answer from an interface that has already answered is ignored and adds no power.
- R4: The test is accepted only when the sum of the collected powers plus the test cost is less than or equal to the budget; equality accepts. A rejected test produces a response with `tresp_accept`=0 to the requester and no vectors.
- R5: If any snapshot answer is still missing after timeout+1 collection cycles, the manager sends a reject response and returns to idle.
- R6: An accepted test emits vectors on consecutive cycles to the configured target, with `vec_idx` = 1, 2, …, count. The last vector carries `dlv_done`=1 and, in the same cycle, a response with `tresp_accept`=1 addressed to the requester.
- R7: In the cycle after any `alarm` bit is high, `throttle` is all ones. In the cycle after `alarm` is all zero, `throttle` is zero.
- R8: A test starts only while the token is held. The token is released with a one-cycle `tok_out` pulse, and `tok_held` low in that same cycle, when a test ends (accept or reject) or after HOLD_CYC cycles of ownership. Whichever comes first applies.
- R9: A request arriving without the token is queued and starts no snapshot. After `tok_in`, queued requests are served one per token visit, oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_valid | input | 1 | configuration command strobe |
| cfg_vec_count | input | VCW | number of test vectors |
| cfg_target | input | AW | address of the core under test |
| cfg_budget | input | BW | power budget |
| cfg_cost | input | BW | power cost of one test |
| cfg_timeout | input | TW | snapshot timeout in cycles |
| treq_valid | input | 1 | test request strobe |
| treq_src | input | AW | address of the requesting interface |
| ss_req | output | N_NI | snapshot request, one bit per interface |
| ss_rsp_valid | input | N_NI | snapshot answer strobe per interface |
| ss_rsp_power | input | N_NI*PW | reported power per interface, interface i at bits i*PW |
| vec_valid | output | 1 | test vector strobe |
| vec_dst | output | AW | vector destination |
| vec_idx | output | VCW | vector number, starting at 1 |
| dlv_done | output | 1 | last vector of the test |
| tresp_valid | output | 1 | test response strobe |
| tresp_dst | output | AW | requester address |
| tresp_accept | output | 1 | 1 accepted and delivered, 0 rejected |
| alarm | input | N_NI | alarm per interface |
| throttle | output | N_NI | throttle command per interface |
| tok_in | input | 1 | token arrives from the previous manager |
| tok_out | output | 1 | token passed to the next manager |
| tok_held | output | 1 | token currently owned |

## Verification
The bench repeats one interface's snapshot answer with a large power value. A design that counted the repeat would push the sum past the budget and reject a test that should pass. A load exactly equal to the budget must be accepted, which catches a strict comparison. One interface stays silent to force the timeout path; a design without the timeout would hang, and the watchdog would expose it. Two requests are queued while the token is away. The bench checks that no snapshot starts before the token arrives and that the responses come back in request order. It also checks that the token leaves after each test and after the hold limit.

// File: rtl/olt_pkg.sv
package olt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_SNAP_ISS,
    ST_SNAP_PROC,
    ST_DECIDE,
    ST_DELIVER
  } mgr_state_e;
endpackage

// File: rtl/olt_reqq.sv
module olt_reqq #(
  parameter int W     = 4,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [PTRW:0] wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[PTRW] != rp[PTRW]) && (wp[PTRW-1:0] == rp[PTRW-1:0]);
  assign dout  = mem[rp[PTRW-1:0]];

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[PTRW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + (PTRW+1)'(1);
      if (pop && !empty) rp <= rp + (PTRW+1)'(1);
    end
  end
endmodule

// File: rtl/olt_snap.sv
module olt_snap #(
  parameter int N_NI = 3,
  parameter int PW   = 8,
  parameter int BW   = 12,
  parameter int TW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              collect,
  input  logic [N_NI-1:0]   rsp_valid,
  input  logic [N_NI*PW-1:0] rsp_power,
  input  logic [TW-1:0]     timeout,
  output logic [N_NI-1:0]   ss_req,
  output logic              all_in,
  output logic              timed_out,
  output logic [BW-1:0]     sum
);
  logic [N_NI-1:0] pending, fresh, left;
  logic [TW-1:0]   timer;
  logic [BW-1:0]   add;

  always_comb begin
    fresh = pending & rsp_valid;
    left  = pending & ~rsp_valid;
    add   = '0;
    for (int i = 0; i < N_NI; i++) begin
      if (fresh[i]) add = add + BW'(rsp_power[i*PW +: PW]);
    end
  end

  assign all_in    = collect && (left == '0);
  assign timed_out = collect && (timer == timeout);

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_req  <= '0;
      pending <= '0;
      timer   <= '0;
      sum     <= '0;
    end else begin
      ss_req <= '0;
      if (issue) begin
        ss_req  <= '1;
        pending <= '1;
        timer   <= '0;
        sum     <= '0;
      end else if (collect) begin
        pending <= left;
        sum     <= sum + add;
        timer   <= timer + TW'(1);
      end
    end
  end
endmodule

// File: rtl/olt_token.sv
module olt_token #(
  parameter int HOLD_CYC    = 40,
  parameter bit START_TOKEN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tok_in,
  input  logic done,
  output logic held,
  output logic own,
  output logic tok_out
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt;
  logic          expire;

  assign expire = held && (cnt == CW'(HOLD_CYC - 1));
  assign own    = held && !expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= START_TOKEN;
      cnt     <= '0;
      tok_out <= 1'b0;
    end else begin
      tok_out <= 1'b0;
      if (held) begin
        if (expire || done) begin
          held    <= 1'b0;
          tok_out <= 1'b1;
          cnt     <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else if (tok_in) begin
        held <= 1'b1;
        cnt  <= '0;
      end
    end
  end
endmodule

// File: rtl/olt_manager.sv
module olt_manager #(
  parameter int N_NI        = 3,
  parameter int PW          = 8,
  parameter int BW          = 12,
  parameter int AW          = 4,
  parameter int VCW         = 4,
  parameter int TW          = 8,
  parameter int QDEPTH      = 4,
  parameter int HOLD_CYC    = 40,
  parameter bit START_TOKEN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_valid,
  input  logic [VCW-1:0]     cfg_vec_count,
  input  logic [AW-1:0]      cfg_target,
  input  logic [BW-1:0]      cfg_budget,
  input  logic [BW-1:0]      cfg_cost,
  input  logic [TW-1:0]      cfg_timeout,
  input  logic               treq_valid,
  input  logic [AW-1:0]      treq_src,
  output logic [N_NI-1:0]    ss_req,
  input  logic [N_NI-1:0]    ss_rsp_valid,
  input  logic [N_NI*PW-1:0] ss_rsp_power,
  output logic               vec_valid,
  output logic [AW-1:0]      vec_dst,
  output logic [VCW-1:0]     vec_idx,
  output logic               dlv_done,
  output logic               tresp_valid,
  output logic [AW-1:0]      tresp_dst,
  output logic               tresp_accept,
  input  logic [N_NI-1:0]    alarm,
  output logic [N_NI-1:0]    throttle,
  input  logic               tok_in,
  output logic               tok_out,
  output logic               tok_held
);
  import olt_pkg::*;

  mgr_state_e     state;
  logic [VCW-1:0] n_vec, vcount;
  logic [AW-1:0]  target, req_src, q_head;
  logic [BW-1:0]  budget, cost, sum;
  logic [TW-1:0]  timeout;
  logic           q_empty, q_full, q_pop, tok_own;
  logic           all_in, timed_out, fits, last_vec, test_end;
  logic [BW:0]    need;

  assign q_pop    = (state == ST_IDLE) && !cfg_valid && !q_empty && tok_own;
  assign need     = {1'b0, sum} + {1'b0, cost};
  assign fits     = need <= {1'b0, budget};
  assign last_vec = (vcount >= n_vec);
  assign test_end = ((state == ST_SNAP_PROC) && !all_in && timed_out) ||
                    ((state == ST_DECIDE) && !fits) ||
                    ((state == ST_DELIVER) && last_vec);

  olt_reqq #(.W(AW), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst), .push(treq_valid), .din(treq_src), .pop(q_pop),
    .dout(q_head), .empty(q_empty), .full(q_full)
  );

  olt_snap #(.N_NI(N_NI), .PW(PW), .BW(BW), .TW(TW)) u_snap (
    .clk(clk), .rst(rst), .issue(state == ST_SNAP_ISS),
    .collect(state == ST_SNAP_PROC), .rsp_valid(ss_rsp_valid),
    .rsp_power(ss_rsp_power), .timeout(timeout), .ss_req(ss_req),
    .all_in(all_in), .timed_out(timed_out), .sum(sum)
  );

  olt_token #(.HOLD_CYC(HOLD_CYC), .START_TOKEN(START_TOKEN)) u_tok (
    .clk(clk), .rst(rst), .tok_in(tok_in), .done(test_end),
    .held(tok_held), .own(tok_own), .tok_out(tok_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      n_vec        <= '0;
      target       <= '0;
      budget       <= '0;
      cost         <= '0;
      timeout      <= '0;
      req_src      <= '0;
      vcount       <= '0;
      vec_valid    <= 1'b0;
      vec_dst      <= '0;
      vec_idx      <= '0;
      dlv_done     <= 1'b0;
      tresp_valid  <= 1'b0;
      tresp_dst    <= '0;
      tresp_accept <= 1'b0;
      throttle     <= '0;
    end else begin
      vec_valid   <= 1'b0;
      dlv_done    <= 1'b0;
      tresp_valid <= 1'b0;
      throttle    <= {N_NI{|alarm}};
      unique case (state)
        ST_IDLE: begin
          if (cfg_valid) begin
            n_vec   <= cfg_vec_count;
            target  <= cfg_target;
            budget  <= cfg_budget;
            cost    <= cfg_cost;
            timeout <= cfg_timeout;
            state   <= ST_CFG;
          end else if (q_pop) begin
            req_src <= q_head;
            state   <= ST_SNAP_ISS;
          end
        end
        ST_CFG:      state <= ST_IDLE;
        ST_SNAP_ISS: state <= ST_SNAP_PROC;
        ST_SNAP_PROC: begin
          if (all_in) begin
            state <= ST_DECIDE;
          end else if (timed_out) begin
            tresp_valid  <= 1'b1;
            tresp_accept <= 1'b0;
            tresp_dst    <= req_src;
            state        <= ST_IDLE;
          end
        end
        ST_DECIDE: begin
          if (fits) begin
            vcount <= VCW'(1);
            state  <= ST_DELIVER;
          end else begin
            tresp_valid  <= 1'b1;
            tresp_accept <= 1'b0;
            tresp_dst    <= req_src;
            state        <= ST_IDLE;
          end
        end
        ST_DELIVER: begin
          vec_valid <= 1'b1;
          vec_dst   <= target;
          vec_idx   <= vcount;
          vcount    <= vcount + VCW'(1);
          if (last_vec) begin
            dlv_done     <= 1'b1;
            tresp_valid  <= 1'b1;
            tresp_accept <= 1'b1;
            tresp_dst    <= req_src;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/olt_manager_chk.sv
module olt_manager_chk #(
  parameter int N_NI = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [N_NI-1:0] alarm,
  input logic [N_NI-1:0] throttle,
  input logic [N_NI-1:0] ss_req,
  input logic            tok_out,
  input logic            tok_held,
  input logic            tresp_valid,
  input logic            tresp_accept,
  input logic            dlv_done,
  input logic            vec_valid
);
  // R7
  throttle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|alarm) |=> (throttle == '1));
  // R7
  throttle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|alarm) |=> (throttle == '0));
  // R8
  token_release_chk: assert property (@(posedge clk) disable iff (rst)
    tok_out |-> !tok_held);
  // R8
  snap_with_token_chk: assert property (@(posedge clk) disable iff (rst)
    (ss_req != '0) |-> $past(tok_held));
  // R3
  snap_fanout_chk: assert property (@(posedge clk) disable iff (rst)
    (ss_req != '0) |-> (ss_req == '1));
  // R6
  accept_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (tresp_valid && tresp_accept) |-> (dlv_done && vec_valid));
  // R4
  reject_no_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (tresp_valid && !tresp_accept) |-> !vec_valid);
endmodule

bind olt_manager olt_manager_chk #(.N_NI(N_NI)) u_chk (
  .clk(clk), .rst(rst), .alarm(alarm), .throttle(throttle), .ss_req(ss_req),
  .tok_out(tok_out), .tok_held(tok_held), .tresp_valid(tresp_valid),
  .tresp_accept(tresp_accept), .dlv_done(dlv_done), .vec_valid(vec_valid)
);

// File: tb/sim_olt_manager.sv
`timescale 1ns/100ps
module sim_olt_manager;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_valid = 1'b0;
  logic [3:0]  cfg_vec_count = '0;
  logic [3:0]  cfg_target = '0;
  logic [11:0] cfg_budget = '0;
  logic [11:0] cfg_cost = '0;
  logic [7:0]  cfg_timeout = '0;
  logic        treq_valid = 1'b0;
  logic [3:0]  treq_src = '0;
  logic [2:0]  ss_req;
  logic [2:0]  ss_rsp_valid = '0;
  logic [23:0] ss_rsp_power = '0;
  logic        vec_valid;
  logic [3:0]  vec_dst;
  logic [3:0]  vec_idx;
  logic        dlv_done;
  logic        tresp_valid;
  logic [3:0]  tresp_dst;
  logic        tresp_accept;
  logic [2:0]  alarm = '0;
  logic [2:0]  throttle;
  logic        tok_in = 1'b0;
  logic        tok_out;
  logic        tok_held;

  always #2.5 clk = ~clk;

  olt_manager u0 (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_vec_count(cfg_vec_count),
    .cfg_target(cfg_target), .cfg_budget(cfg_budget), .cfg_cost(cfg_cost),
    .cfg_timeout(cfg_timeout), .treq_valid(treq_valid), .treq_src(treq_src),
    .ss_req(ss_req), .ss_rsp_valid(ss_rsp_valid), .ss_rsp_power(ss_rsp_power),
    .vec_valid(vec_valid), .vec_dst(vec_dst), .vec_idx(vec_idx),
    .dlv_done(dlv_done), .tresp_valid(tresp_valid), .tresp_dst(tresp_dst),
    .tresp_accept(tresp_accept), .alarm(alarm), .throttle(throttle),
    .tok_in(tok_in), .tok_out(tok_out), .tok_held(tok_held)
  );

  int total = 0;
  int bad = 0;
  int tok_out_cnt = 0;
  int ss_cnt = 0;
  int done_cnt = 0;
  bit finished = 1'b0;
  // item: [23:16] kind (1 vector, 2 response), [15:8] address, [7:0] data
  logic [23:0] expq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sb_take(input logic [23:0] item);
    logic [23:0] e;
    if (expq.size() == 0) begin
      chk(1'b0, "R4 R5 R6 unexpected output", int'(item), 0);
    end else begin
      e = expq.pop_front();
      chk(e == item, "R4 R5 R6 R9 scoreboard item", int'(item), int'(e));
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (tok_out) tok_out_cnt++;
      if (ss_req != '0) ss_cnt++;
      if (dlv_done) done_cnt++;
      if (vec_valid) sb_take({8'd1, 4'd0, vec_dst, dlv_done, 3'd0, vec_idx});
      if (tresp_valid) sb_take({8'd2, 4'd0, tresp_dst, 7'd0, tresp_accept});
    end
  end

  task automatic exp_accept(input int tgt, input int n, input int src);
    for (int k = 1; k <= n; k++)
      expq.push_back({8'd1, 4'd0, 4'(tgt), (k == n), 3'd0, 4'(k)});
    expq.push_back({8'd2, 4'd0, 4'(src), 8'd1});
  endtask

  task automatic exp_reject(input int src);
    expq.push_back({8'd2, 4'd0, 4'(src), 8'd0});
  endtask

  task automatic do_cfg(input int n, input int tgt, input int bud, input int cst, input int to);
    @(negedge clk);
    cfg_vec_count = 4'(n); cfg_target = 4'(tgt); cfg_budget = 12'(bud);
    cfg_cost = 12'(cst); cfg_timeout = 8'(to); cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic do_req(input int src);
    @(negedge clk);
    treq_src = 4'(src); treq_valid = 1'b1;
    @(negedge clk);
    treq_valid = 1'b0;
  endtask

  task automatic give_tok();
    @(negedge clk);
    tok_in = 1'b1;
    @(negedge clk);
    tok_in = 1'b0;
  endtask

  // answers a snapshot; interface 0 answers twice, the second time with 50
  task automatic respond(input int p0, input int p1, input int p2, input bit skip2);
    do @(negedge clk); while (ss_req == '0);
    ss_rsp_power = {8'(p2), 8'(p1), 8'(p0)};
    ss_rsp_valid = 3'b001;
    @(negedge clk);
    ss_rsp_power = {8'(p2), 8'(p1), 8'd50};
    ss_rsp_valid = 3'b011;
    @(negedge clk);
    ss_rsp_valid = skip2 ? 3'b000 : 3'b100;
    @(negedge clk);
    ss_rsp_valid = 3'b000;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ss_req == 0, "R1 ss_req", ss_req, 0);
    chk(vec_valid == 0, "R1 vec_valid", vec_valid, 0);
    chk(tresp_valid == 0, "R1 tresp_valid", tresp_valid, 0);
    chk(throttle == 0, "R1 throttle", throttle, 0);
    chk(tok_out == 0, "R1 tok_out", tok_out, 0);
    chk(tok_held == 1, "R1 tok_held", tok_held, 1);

    // R2 R3 R6: accepted test, duplicate answer must be ignored (60+10 <= 100)
    do_cfg(3, 5, 100, 10, 20);
    exp_accept(5, 3, 2);
    do_req(2);
    respond(10, 20, 30, 1'b0);
    drain();
    chk(ss_cnt == 1, "R3 snapshot count", ss_cnt, 1);
    chk(done_cnt == 1, "R6 delivery done count", done_cnt, 1);
    // R8 token leaves after the test
    chk(tok_out_cnt == 1, "R8 token passed after test", tok_out_cnt, 1);
    chk(tok_held == 0, "R8 token released", tok_held, 0);

    // R9 requests queue without the token
    do_req(7);
    do_req(3);
    repeat (10) @(negedge clk);
    chk(ss_cnt == 1, "R9 no snapshot without token", ss_cnt, 1);
    // R4 over budget: 120 + 10 > 100
    exp_reject(7);
    give_tok();
    respond(40, 40, 40, 1'b0);
    drain();
    chk(tok_out_cnt == 2, "R8 token passed after reject", tok_out_cnt, 2);
    // R5 interface 2 silent -> timeout reject for the second queued request
    exp_reject(3);
    give_tok();
    respond(10, 10, 0, 1'b1);
    drain();
    chk(tok_out_cnt == 3, "R8 token passed after timeout", tok_out_cnt, 3);

    // R7 throttle broadcast
    @(negedge clk);
    alarm = 3'b010;
    @(negedge clk);
    chk(throttle == 3'b111, "R7 throttle on alarm", throttle, 7);
    alarm = 3'b000;
    @(negedge clk);
    chk(throttle == 3'b000, "R7 throttle cleared", throttle, 0);

    // R8 hold limit
    give_tok();
    chk(tok_held == 1, "R8 token taken", tok_held, 1);
    repeat (45) @(negedge clk);
    chk(tok_held == 0, "R8 token expired", tok_held, 0);
    chk(tok_out_cnt == 4, "R8 token passed on expiry", tok_out_cnt, 4);

    // R4 boundary: 60 + 10 == 70 accepted; R2 new target and count
    do_cfg(1, 9, 70, 10, 20);
    give_tok();
    exp_accept(9, 1, 4);
    do_req(4);
    respond(20, 20, 20, 1'b0);
    drain();
    chk(done_cnt == 2, "R6 boundary delivery done", done_cnt, 2);
    chk(expq.size() == 0, "R4 R6 all expected items seen", expq.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule